// File: doc/BRIEF.md
# DDR Write Leveling Sequencer

This block aligns, lane by lane, the launch of each byte lane's data strobe with the clock as it arrives at the DRAM. The clock-to-strobe skew differs for each DRAM on a module, so each lane needs its own delay setting. After a start request, the sequencer issues a mode-register write that sets the leveling-enable bit (bit 7 of mode register 1). This puts the DRAM into a mode where it samples its clock on each strobe edge and returns the sampled level on a data pin.

For each lane in turn, the sequencer steps a trial delay upward from zero. At each step it fires one strobe pulse and waits a fixed number of cycles for the returned level to settle. It then samples the lane's feedback bit. The search for a lane ends at the first step whose sample is 1 while the sample at the step before was 0. That delay is kept as the lane's result. If the search reaches the top of the delay range without finding that rise, the lane is marked failed and its delay is left at zero. After the last lane, a second mode-register write clears the leveling-enable bit. The block then signals completion and holds its results until the next start.

The delay outputs drive external per-lane delay lines. During a search, the lane under test shows its trial value. The feedback bits come back from the DRAM's data pins.

Top module: `wlvl_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `mr_wr`, `mr_lvl` and every `dqs_pulse`, `lane_fail` and `lane_dly` bit are 0, and `mr_sel` is 0.
- R2: `start` is honoured only when the block is neither busy nor done-idle-waiting is required; it is honoured when `busy` is 0. On start, the block raises `mr_wr` with `mr_sel`=1 (mode register 1) and `mr_lvl`=1 (bit 7 set), holding all three until `mr_ack` is sampled high. A `start` while `busy` is 1 has no effect.
- R3: Each trial is one cycle with exactly one `dqs_pulse` bit high, the bit whose index equals the lane under test. Then come WAIT_CYC cycles with no pulse. The feedback is then sampled in the following cycle. The lane's `lane_dly` field shows the trial delay through all of these cycles.
- R4: A sample that does not end the lane raises the trial delay by exactly 1, and the next pulse follows in the next cycle.
- R5: A lane ends at the first sample of 1 whose previous sample, taken one delay step lower in the same lane, was 0. That trial delay is stored as the lane's result and held on `lane_dly` until the next start.
- R6: A sample of 1 at delay 0, or any 1 seen before a 0 has been seen in that lane, does not end the lane.
- R7: If the sample at the top delay (2**DLY_W-1) does not end the lane, the lane's `lane_fail` bit is set, its `lane_dly` field is 0, and the next lane begins. A rise found at the top delay counts as a pass.
- R8: Lanes are searched in ascending index order, each starting at delay 0. Lanes not yet searched show delay 0.
- R9: After the last lane, `mr_wr` is raised with `mr_sel`=1 and `mr_lvl`=0 until `mr_ack` is sampled. Then `done` goes high and stays high, with `busy` low, until the next start. `busy` is high from the cycle after start up to and including that final write.
- R10: `mr_ack` has no effect outside a pending mode-register write.
- R11: A start clears every stored lane delay and failure flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a leveling run (one-cycle request) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; results valid |
| mr_wr | output | 1 | Mode-register write request, held until acknowledged |
| mr_sel | output | 3 | Mode register index (1 during a request) |
| mr_lvl | output | 1 | Value for the leveling-enable bit (bit 7) |
| mr_ack | input | 1 | Mode-register write accepted |
| dqs_pulse | output | LANES | One-cycle strobe pulse request, one bit per lane |
| lvl_fb | input | LANES | Sampled clock level returned per lane |
| lane_dly | output | LANES*DLY_W | Per-lane strobe delay, lane i in bits [i*DLY_W +: DLY_W] |
| lane_fail | output | LANES | Lane found no rise within the delay range |

## Verification
A wrong trial counter or lane index shows on the very next pulse cycle: either the wrong `dqs_pulse` bit is high, or the active lane's `lane_dly` field carries an unexpected value. A faulty wait timer moves the next pulse earlier or later by at least one cycle. A broken rise detector either ends a lane one step early, at a leading 1, or runs past the rise. That is visible as an extra pulse within WAIT_CYC+2 cycles and as a wrong stored delay at `done`. Since the bench predicts every output on every cycle, any such fault is reported in the cycle where it first appears.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MR_ON,
        ST_PULSE,
        ST_WAIT,
        ST_EVAL,
        ST_MR_OFF,
        ST_DONE
    } wl_state_t;

    // Mode register that holds the leveling-enable bit
    localparam logic [2:0] MR_LVL_SEL = 3'd1;

    // Outcome of evaluating one feedback sample
    typedef struct packed {
        logic finish;   // lane search ends this cycle
        logic failed;   // lane ended without a rise
    } wl_verdict_t;

    function automatic logic is_search(input wl_state_t s);
        return (s == ST_PULSE) || (s == ST_WAIT) || (s == ST_EVAL);
    endfunction

    function automatic logic is_mrw(input wl_state_t s);
        return (s == ST_MR_ON) || (s == ST_MR_OFF);
    endfunction

    function automatic wl_verdict_t judge(input logic rise, input logic at_top);
        wl_verdict_t v;
        v.finish = rise | at_top;
        v.failed = ~rise & at_top;
        return v;
    endfunction

endpackage

// File: rtl/wlvl_wait_timer.sv
module wlvl_wait_timer #(
    parameter int WAIT_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign expired = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wlvl_rise_detect.sv
module wlvl_rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sample_en,
    input  logic bit_in,
    output logic rise
);
    logic prev_bit;
    logic prev_vld;

    assign rise = prev_vld && !prev_bit && bit_in;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_bit <= 1'b0;
            prev_vld <= 1'b0;
        end else if (sample_en) begin
            prev_bit <= bit_in;
            prev_vld <= 1'b1;
        end
    end
endmodule

// File: rtl/wlvl_result_bank.sv
module wlvl_result_bank #(
    parameter int LANES  = 4,
    parameter int DLY_W  = 5,
    parameter int LANE_W = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    wr_en,
    input  logic [LANE_W-1:0]       wr_lane,
    input  logic                    wr_fail,
    input  logic [DLY_W-1:0]        wr_dly,
    output logic [LANES*DLY_W-1:0]  res_dly,
    output logic [LANES-1:0]        res_fail
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DLY_W-1:0] dly_q;
        logic             fail_q;
        logic             sel;

        assign sel = wr_en && (wr_lane == LANE_W'(g));

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                dly_q  <= '0;
                fail_q <= 1'b0;
            end else if (sel) begin
                dly_q  <= wr_fail ? '0 : wr_dly;
                fail_q <= wr_fail;
            end
        end

        assign res_dly[g*DLY_W +: DLY_W] = dly_q;
        assign res_fail[g]               = fail_q;
    end
endmodule

// File: rtl/wlvl_ctrl.sv
module wlvl_ctrl
    import wlvl_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int DLY_W    = 5,
    parameter int WAIT_CYC = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    output logic                   busy,
    output logic                   done,
    output logic                   mr_wr,
    output logic [2:0]             mr_sel,
    output logic                   mr_lvl,
    input  logic                   mr_ack,
    output logic [LANES-1:0]       dqs_pulse,
    input  logic [LANES-1:0]       lvl_fb,
    output logic [LANES*DLY_W-1:0] lane_dly,
    output logic [LANES-1:0]       lane_fail
);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);
    localparam logic [DLY_W-1:0]  DLY_TOP   = {DLY_W{1'b1}};

    wl_state_t         st, st_nx;
    logic [LANE_W-1:0] lane_idx;
    logic [DLY_W-1:0]  trial;

    logic        launch;
    logic        wait_over;
    logic        rise;
    logic        fb_cur;
    logic        at_top;
    wl_verdict_t verdict;
    logic        lane_end;
    logic        last_lane;
    logic [LANES*DLY_W-1:0] res_dly;

    assign launch    = ((st == ST_IDLE) || (st == ST_DONE)) && start;
    assign fb_cur    = lvl_fb[lane_idx];
    assign at_top    = (trial == DLY_TOP);
    assign verdict   = judge(rise, at_top);
    assign lane_end  = (st == ST_EVAL) && verdict.finish;
    assign last_lane = (lane_idx == LANE_LAST);

    wlvl_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (st == ST_WAIT),
        .expired (wait_over)
    );

    wlvl_rise_detect u_rise (
        .clk       (clk),
        .rst       (rst),
        .clear     (launch || lane_end),
        .sample_en (st == ST_EVAL),
        .bit_in    (fb_cur),
        .rise      (rise)
    );

    wlvl_result_bank #(.LANES(LANES), .DLY_W(DLY_W), .LANE_W(LANE_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .clear    (launch),
        .wr_en    (lane_end),
        .wr_lane  (lane_idx),
        .wr_fail  (verdict.failed),
        .wr_dly   (trial),
        .res_dly  (res_dly),
        .res_fail (lane_fail)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE, ST_DONE: if (start) st_nx = ST_MR_ON;
            ST_MR_ON:         if (mr_ack) st_nx = ST_PULSE;
            ST_PULSE:         st_nx = ST_WAIT;
            ST_WAIT:          if (wait_over) st_nx = ST_EVAL;
            ST_EVAL: begin
                if (!verdict.finish)  st_nx = ST_PULSE;
                else if (last_lane)   st_nx = ST_MR_OFF;
                else                  st_nx = ST_PULSE;
            end
            ST_MR_OFF:        if (mr_ack) st_nx = ST_DONE;
            default:          st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            lane_idx <= '0;
            trial    <= '0;
        end else begin
            st <= st_nx;
            if (launch) begin
                lane_idx <= '0;
                trial    <= '0;
            end else if (lane_end) begin
                trial <= '0;
                if (!last_lane) lane_idx <= lane_idx + 1'b1;
            end else if (st == ST_EVAL) begin
                trial <= trial + 1'b1;
            end
        end
    end

    assign busy   = (st != ST_IDLE) && (st != ST_DONE);
    assign done   = (st == ST_DONE);
    assign mr_wr  = is_mrw(st);
    assign mr_sel = is_mrw(st) ? MR_LVL_SEL : 3'd0;
    assign mr_lvl = (st == ST_MR_ON);

    for (genvar g = 0; g < LANES; g++) begin : g_out
        logic active;
        assign active = is_search(st) && (lane_idx == LANE_W'(g));
        assign dqs_pulse[g] = (st == ST_PULSE) && (lane_idx == LANE_W'(g));
        assign lane_dly[g*DLY_W +: DLY_W] = active ? trial : res_dly[g*DLY_W +: DLY_W];
    end
endmodule

// File: rtl/wlvl_ctrl_chk.sv
module wlvl_ctrl_chk #(
    parameter int LANES = 4,
    parameter int DLY_W = 5
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic                   mr_wr,
    input logic [2:0]             mr_sel,
    input logic                   mr_lvl,
    input logic                   mr_ack,
    input logic [LANES-1:0]       dqs_pulse,
    input logic [LANES*DLY_W-1:0] lane_dly,
    input logic [LANES-1:0]       lane_fail
);
    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dqs_pulse)); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (|dqs_pulse) |=> (dqs_pulse == '0)); // R3
    AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (|dqs_pulse) |-> (busy && !mr_wr)); // R3
    AST_MR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mr_wr && !mr_ack) |=> (mr_wr && (mr_lvl == $past(mr_lvl)))); // R2
    AST_MR_TARGET: assert property (@(posedge clk) disable iff (rst)
        mr_wr |-> (mr_sel == 3'd1)); // R2
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !mr_wr && (dqs_pulse == '0))); // R9
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R9

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
            lane_fail[g] |-> (lane_dly[g*DLY_W +: DLY_W] == '0)); // R7
        AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
            (lane_fail[g] && !(start && !busy)) |=> lane_fail[g]); // R5
    end
endmodule

bind wlvl_ctrl wlvl_ctrl_chk #(.LANES(LANES), .DLY_W(DLY_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mr_wr     (mr_wr),
    .mr_sel    (mr_sel),
    .mr_lvl    (mr_lvl),
    .mr_ack    (mr_ack),
    .dqs_pulse (dqs_pulse),
    .lane_dly  (lane_dly),
    .lane_fail (lane_fail)
);

// File: tb/wlvl_ctrl_test.sv
module wlvl_ctrl_test;
    localparam int LANES    = 4;
    localparam int DLY_W    = 5;
    localparam int WAIT_CYC = 16;
    localparam int DLY_MAX  = 31;
    localparam int OW       = 7 + 2*LANES + LANES*DLY_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic mr_ack = 1'b0;
    logic busy, done, mr_wr, mr_lvl;
    logic [2:0] mr_sel;
    logic [LANES-1:0] dqs_pulse, lane_fail;
    logic [LANES-1:0] lvl_fb = '0;
    logic [LANES*DLY_W-1:0] lane_dly;

    always #5 clk = ~clk;

    wlvl_ctrl #(.LANES(LANES), .DLY_W(DLY_W), .WAIT_CYC(WAIT_CYC)) uut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .mr_wr(mr_wr), .mr_sel(mr_sel), .mr_lvl(mr_lvl), .mr_ack(mr_ack),
        .dqs_pulse(dqs_pulse), .lvl_fb(lvl_fb), .lane_dly(lane_dly),
        .lane_fail(lane_fail)
    );

    // DRAM-side stand-in: sampled level is 1 at or above thr, or below low
    int thr [LANES];
    int low [LANES];
    int edly [LANES];
    bit efail [LANES];
    int n_cmp = 0;
    int n_bad = 0;

    function automatic bit fbv(int lane, int d);
        return (d >= thr[lane]) || (d < low[lane]);
    endfunction

    always @(negedge clk) begin
        for (int i = 0; i < LANES; i++)
            lvl_fb[i] <= fbv(i, int'(lane_dly[i*DLY_W +: DLY_W]));
    end

    function automatic logic [OW-1:0] observed();
        return {busy, done, mr_wr, mr_lvl, mr_sel, dqs_pulse, lane_fail, lane_dly};
    endfunction

    function automatic logic [OW-1:0] expv(bit b, bit dn, bit wr, bit lv,
                                           int plane, int cur, int d);
        logic [LANES-1:0] p, f;
        logic [LANES*DLY_W-1:0] dl;
        p = '0; f = '0; dl = '0;
        if (plane >= 0) p[plane] = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            f[i] = efail[i];
            dl[i*DLY_W +: DLY_W] = DLY_W'((i == cur) ? d : edly[i]);
        end
        return {b, dn, wr, lv, (wr ? 3'd1 : 3'd0), p, f, dl};
    endfunction

    task automatic tick(input logic [OW-1:0] e, input string tag);
        logic [OW-1:0] a;
        @(negedge clk);
        a = observed();
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, a, e);
        end
    endtask

    task automatic check_lane(int lane, int d, bit f, string tag);
        n_cmp++;
        if (int'(lane_dly[lane*DLY_W +: DLY_W]) != d || lane_fail[lane] != f) begin
            n_bad++;
            $display("FAIL %s lane %0d: actual dly %0d fail %0b expected dly %0d fail %0b",
                     tag, lane, lane_dly[lane*DLY_W +: DLY_W], lane_fail[lane], d, f);
        end
    endtask

    task automatic run(input int ack_lat, input bit noise);
        start = 1'b1;
        for (int i = 0; i < LANES; i++) begin edly[i] = 0; efail[i] = 0; end
        for (int k = 0; k <= ack_lat; k++) begin
            tick(expv(1, 0, 1, 1, -1, -1, 0),
                 (k == 0) ? "R11 results cleared / R2 level-on write" : "R2 level-on write held");
            start  = 1'b0;
            mr_ack = (k == ack_lat);
        end
        for (int lane = 0; lane < LANES; lane++) begin
            int  d    = 0;
            bit  have = 0;
            bit  prv  = 0;
            bit  fin  = 0;
            while (!fin) begin
                bit b;
                tick(expv(1, 0, 0, 0, lane, lane, d), (d == 0) ? "R8 lane order" : "R3 pulse");
                mr_ack = 1'b0;
                for (int w = 0; w < WAIT_CYC; w++) begin
                    tick(expv(1, 0, 0, 0, -1, lane, d),
                         (noise && w == 3) ? "R2/R10 stray start and ack ignored" : "R3 wait");
                    start  = noise && (w == 2);
                    mr_ack = noise && (w == 2);
                end
                tick(expv(1, 0, 0, 0, -1, lane, d), "R4 sample");
                b = fbv(lane, d);
                if (have && !prv && b) begin
                    edly[lane] = d; fin = 1;
                end else if (d == DLY_MAX) begin
                    edly[lane] = 0; efail[lane] = 1; fin = 1;
                end else begin
                    prv = b; have = 1; d++;
                end
            end
        end
        for (int k = 0; k <= ack_lat; k++) begin
            tick(expv(1, 0, 1, 0, -1, -1, 0), "R9 level-off write");
            mr_ack = (k == ack_lat);
        end
        tick(expv(0, 1, 0, 0, -1, -1, 0), "R9 done");
        mr_ack = 1'b0;
        tick(expv(0, 1, 0, 0, -1, -1, 0), "R9 done held");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < LANES; i++) begin thr[i] = 0; low[i] = 0; edly[i] = 0; efail[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tick(expv(0, 0, 0, 0, -1, -1, 0), "R1 reset state");

        // Run 1: clean rises, one at the top delay, one at delay 1
        thr[0] = 5;  thr[1] = 12; thr[2] = 31; thr[3] = 1;
        run(2, 0);
        check_lane(0, 5,  0, "R5 rise found");
        check_lane(1, 12, 0, "R5 rise found");
        check_lane(2, 31, 0, "R7 rise at top delay passes");
        check_lane(3, 1,  0, "R5 earliest rise");

        // Run 2: restart from done, leading ones, never-low, never-high lanes
        thr[0] = 0;  thr[1] = 40; thr[2] = 8; thr[3] = 20;
        low[2] = 3;
        run(0, 1);
        check_lane(0, 0,  1, "R6 high from delay 0 never counts");
        check_lane(1, 0,  1, "R7 no rise in range");
        check_lane(2, 8,  0, "R6 leading ones skipped");
        check_lane(3, 20, 0, "R5 rise found");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule